// File: doc/BRIEF.md
# Configuration File Header Parser

This block takes in the byte stream of a device configuration file and walks its header to find the configuration payload. First it throws away a preamble whose size is given by a 16-bit length. Then it reads a second 16-bit word and ignores its value. After that it steps through records, each of which begins with a single-character tag. The four text records carry the design name, the part, the date and the time. Their characters appear on a side output, each tagged with a field index. The payload record has a 32-bit length. The parser sends exactly that many bytes downstream over a valid/ready handshake and then reports completion.

Parsing stops with a sticky error flag in two cases. One is a tag the parser does not recognise. The other is an input stream that ends before the declared lengths are met; the upstream marks the end of its stream with a last flag on the final byte. While the payload is flowing, the parser passes bytes straight through with no internal buffer. In every other state it accepts input bytes unconditionally.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `done`, `tag_err` and `trunc_err` are 0, and neither `txt_valid` nor `out_valid` is asserted. The parser then expects the preamble length.
- R2: The first two bytes form a big-endian 16-bit count N. The N bytes that follow are consumed without producing any output, whatever their values.
- R3: The next two bytes are consumed and their value has no effect on the parse. The byte after them is read as the first tag.
- R4: Tags 0x61..0x64 ('a'..'d') are text records. Each has a big-endian 16-bit length and then that many characters. Each character appears on `txt_data` with `txt_valid` and `txt_field` = tag − 0x61 (0..3). `txt_last` is set on the final character of the record.
- R5: Tag 0x65 ('e') is the payload record. It has a 32-bit length, most significant byte first. Exactly that many following bytes appear in order on `out_data`, and `out_last` is set only on the final one.
- R6: During the payload, `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A byte offered while `out_ready` is 0 stays on `out_data` and is not consumed.
- R7: `done` rises in the cycle after the final payload byte is accepted and stays set until reset. Bytes that arrive after that are accepted and discarded, and neither output port shows anything.
- R8: A tag outside 0x61..0x65 (for example 0x60 or 0x66) sets a sticky `tag_err` in the next cycle. After that, further bytes are accepted and discarded with no output.
- R9: A zero length moves straight on without consuming any body bytes. A zero-length preamble or text record goes on to the next field. A zero-length payload raises `done` right after its fourth length byte.
- R10: If a byte marked `in_last` is accepted before the payload is complete, `trunc_err` is set in the next cycle and stays set. An in_last byte that is itself an unknown tag reports `tag_err` only. An in_last byte that is the final payload byte is not a truncation.
- R11: Asserting reset in the middle of a parse returns the parser to the preamble-length state, and a complete file sent afterwards parses correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the input stream |
| in_ready | output | 1 | Parser accepts the input byte |
| txt_valid | output | 1 | Text character valid |
| txt_data | output | 8 | Text character |
| txt_field | output | 2 | Text field index (0..3 for tags 'a'..'d') |
| txt_last | output | 1 | Final character of the text record |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Downstream accepts the payload byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte |
| done | output | 1 | Payload fully delivered (sticky) |
| tag_err | output | 1 | Unknown tag seen (sticky) |
| trunc_err | output | 1 | Stream ended early (sticky) |

## Verification
A full file with a 258-byte preamble and a 261-byte payload checks byte order. A little-endian reading of either length would skip the wrong number of bytes or hang. Text records arrive in field order, include one of zero length, and use distinct characters, so a swapped field index or a misplaced last strobe is visible. A short payload sent under periodic back-pressure separates a correct pass-through from one that drops or repeats stalled bytes. Separate streams cover the tags on either side of the legal range, an end-of-stream marker at several depths (preamble, text, payload, on the tag byte itself, on the final payload byte), a zero-length payload, and a reset in the middle of a parse.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [3:0] {
    ST_PRE_LEN, ST_PRE_SKIP, ST_HDR_LEN, ST_TAG, ST_TXT_LEN,
    ST_TXT, ST_PAY_LEN, ST_PAY, ST_DONE, ST_BAD_TAG, ST_TRUNC
  } cfgp_state_t;

  typedef enum logic [1:0] {
    LEN_HOLD, LEN_CLR, LEN_SHIFT, LEN_DEC
  } cfgp_len_op_t;

  localparam logic [7:0] TAG_TXT_FIRST = 8'h61;
  localparam logic [7:0] TAG_TXT_LAST  = 8'h64;
  localparam logic [7:0] TAG_PAYLOAD   = 8'h65;

  function automatic logic tag_is_text(input logic [7:0] t);
    return (t >= TAG_TXT_FIRST) && (t <= TAG_TXT_LAST);
  endfunction

  function automatic logic [1:0] tag_field(input logic [7:0] t);
    logic [7:0] d;
    d = t - TAG_TXT_FIRST;
    return d[1:0];
  endfunction

  function automatic logic is_terminal(input cfgp_state_t s);
    return (s == ST_DONE) || (s == ST_BAD_TAG) || (s == ST_TRUNC);
  endfunction

endpackage

// File: rtl/cfgp_len_reg.sv
module cfgp_len_reg
  import cfgp_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  cfgp_len_op_t       op,
  input  logic [7:0]         din,
  output logic [LEN_W-1:0]   cnt_o,
  output logic [LEN_W-1:0]   shifted_o,
  output logic               is_one_o
);

  logic [LEN_W-1:0] cnt_q;

  assign shifted_o = {cnt_q[LEN_W-9:0], din};
  assign is_one_o  = (cnt_q == LEN_W'(1));
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case (op)
        LEN_CLR:   cnt_q <= '0;
        LEN_SHIFT: cnt_q <= shifted_o;
        LEN_DEC:   cnt_q <= cnt_q - LEN_W'(1);
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/cfgp_tag_dec.sv
module cfgp_tag_dec
  import cfgp_pkg::*;
(
  input  logic [7:0] tag,
  output logic       is_text,
  output logic       is_payload,
  output logic [1:0] field
);

  assign is_text    = tag_is_text(tag);
  assign is_payload = (tag == TAG_PAYLOAD);
  assign field      = tag_field(tag);

endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
  import cfgp_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       txt_valid,
  output logic [7:0] txt_data,
  output logic [1:0] txt_field,
  output logic       txt_last,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       done,
  output logic       tag_err,
  output logic       trunc_err
);

  cfgp_state_t      st_q, st_n;
  logic [1:0]       idx_q, idx_n;
  logic [1:0]       field_q, field_n;
  cfgp_len_op_t     len_op;
  logic [LEN_W-1:0] cnt, shifted;
  logic             cnt_is_one;
  logic             tag_text, tag_pay;
  logic [1:0]       tag_fld;

  // named internal events
  logic take;
  logic pay_fire;
  logic pay_final;
  logic rec_start;

  cfgp_len_reg #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst), .op(len_op), .din(in_data),
    .cnt_o(cnt), .shifted_o(shifted), .is_one_o(cnt_is_one)
  );

  cfgp_tag_dec u_tag (
    .tag(in_data), .is_text(tag_text), .is_payload(tag_pay), .field(tag_fld)
  );

  assign in_ready  = (st_q == ST_PAY) ? out_ready : 1'b1;
  assign take      = in_valid && in_ready;
  assign out_valid = (st_q == ST_PAY) && in_valid;
  assign out_data  = in_data;
  assign out_last  = (st_q == ST_PAY) && cnt_is_one;
  assign txt_valid = (st_q == ST_TXT) && in_valid;
  assign txt_data  = in_data;
  assign txt_field = field_q;
  assign txt_last  = (st_q == ST_TXT) && cnt_is_one;
  assign done      = (st_q == ST_DONE);
  assign tag_err   = (st_q == ST_BAD_TAG);
  assign trunc_err = (st_q == ST_TRUNC);
  assign pay_fire  = out_valid && out_ready;
  assign pay_final = pay_fire && out_last;
  assign rec_start = take && (st_q == ST_TAG);

  always_comb begin
    st_n    = st_q;
    idx_n   = idx_q;
    field_n = field_q;
    len_op  = LEN_HOLD;
    if (take) begin
      case (st_q)
        ST_PRE_LEN, ST_TXT_LEN: begin
          len_op = LEN_SHIFT;
          idx_n  = idx_q + 2'd1;
          if (idx_q == 2'd1) begin
            idx_n = 2'd0;
            if (st_q == ST_PRE_LEN)
              st_n = (shifted == '0) ? ST_HDR_LEN : ST_PRE_SKIP;
            else
              st_n = (shifted == '0) ? ST_TAG : ST_TXT;
          end
        end
        ST_PRE_SKIP: begin
          len_op = LEN_DEC;
          if (cnt_is_one) st_n = ST_HDR_LEN;
        end
        ST_HDR_LEN: begin
          idx_n = idx_q + 2'd1;
          if (idx_q == 2'd1) begin
            idx_n = 2'd0;
            st_n  = ST_TAG;
          end
        end
        ST_TAG: begin
          len_op = LEN_CLR;
          if (tag_text) begin
            field_n = tag_fld;
            st_n    = ST_TXT_LEN;
          end else if (tag_pay) begin
            st_n = ST_PAY_LEN;
          end else begin
            st_n = ST_BAD_TAG;
          end
        end
        ST_TXT: begin
          len_op = LEN_DEC;
          if (cnt_is_one) st_n = ST_TAG;
        end
        ST_PAY_LEN: begin
          len_op = LEN_SHIFT;
          idx_n  = idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            idx_n = 2'd0;
            st_n  = (shifted == '0) ? ST_DONE : ST_PAY;
          end
        end
        ST_PAY: begin
          len_op = LEN_DEC;
          if (cnt_is_one) st_n = ST_DONE;
        end
        default: ;
      endcase
      if (in_last && !is_terminal(st_q) && !is_terminal(st_n))
        st_n = ST_TRUNC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_PRE_LEN;
      idx_q   <= 2'd0;
      field_q <= 2'd0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      field_q <= field_n;
    end
  end

endmodule

// File: rtl/cfg_hdr_parser_chk.sv
module cfg_hdr_parser_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic in_last,
  input logic out_valid,
  input logic out_ready,
  input logic txt_valid,
  input logic done,
  input logic tag_err,
  input logic trunc_err,
  input logic pay_final
);

  // R6
  pay_ready_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (in_ready == out_ready));

  // R7
  done_after_final_chk: assert property (@(posedge clk) disable iff (rst)
    pay_final |=> done);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R7
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!out_valid && !txt_valid));

  // R8
  tag_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    tag_err |=> (tag_err && !out_valid && !txt_valid));

  // R10
  trunc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    trunc_err |=> trunc_err);

  // R10
  trunc_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(trunc_err) |-> $past(in_last && in_valid && in_ready));

endmodule

bind cfg_hdr_parser cfg_hdr_parser_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .txt_valid(txt_valid), .done(done), .tag_err(tag_err),
  .trunc_err(trunc_err), .pay_final(pay_final)
);

// File: tb/cfg_hdr_parser_tb.sv
module cfg_hdr_parser_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       txt_valid;
  logic [7:0] txt_data;
  logic [1:0] txt_field;
  logic       txt_last;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;
  logic       done;
  logic       tag_err;
  logic       trunc_err;

  always #10 clk = ~clk;

  cfg_hdr_parser dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .txt_valid(txt_valid),
    .txt_data(txt_data), .txt_field(txt_field), .txt_last(txt_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done(done), .tag_err(tag_err), .trunc_err(trunc_err)
  );

  int n_chk = 0;
  int n_err = 0;
  bit bp_mode = 1'b0;
  int bp_ctr = 0;
  int stalls = 0;

  logic [7:0] tdat [0:511];
  logic [1:0] tfld [0:511];
  bit         tlst [0:511];
  int         tn = 0;
  logic [7:0] pdat [0:511];
  bit         plst [0:511];
  int         pn = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    tn = 0; pn = 0; stalls = 0; bp_ctr = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit last);
    int guard = 0;
    bit got = 1'b0;
    while (!got) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = b; in_last = last;
      out_ready = bp_mode ? ((bp_ctr % 3) != 0) : 1'b1;
      bp_ctr++;
      #5;
      if (in_ready) begin
        got = 1'b1;
        if (txt_valid) begin
          tdat[tn] = txt_data; tfld[tn] = txt_field; tlst[tn] = txt_last; tn++;
        end
        if (out_valid) begin
          pdat[pn] = out_data; plst[pn] = out_last; pn++;
        end
      end else begin
        if (out_valid) begin
          stalls++;
          chk("R6", "stalled out_data", out_data, b);
        end
        guard++;
        if (guard > 50) begin
          chk("R6", "input never accepted", 0, 1);
          got = 1'b1;
        end
      end
      @(posedge clk);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    #5;
  endtask

  task automatic send16(input logic [15:0] v);
    send(v[15:8], 1'b0); send(v[7:0], 1'b0);
  endtask

  task automatic send32(input logic [31:0] v);
    send16(v[31:16]); send16(v[15:0]);
  endtask

  task automatic send_txt(input logic [7:0] tag, input string s);
    send(tag, 1'b0);
    send16(16'(s.len()));
    for (int i = 0; i < s.len(); i++) send(s[i], 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    settle();
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "done", int'(done), 0);
    chk("R1", "tag_err", int'(tag_err), 0);
    chk("R1", "trunc_err", int'(trunc_err), 0);
    chk("R1", "outputs idle", int'(txt_valid | out_valid), 0);
  endtask

  task automatic t_full();
    do_reset();
    send16(16'h0102);
    for (int i = 0; i < 258; i++) send(8'(i * 7), 1'b0);
    settle();
    chk("R2", "text during preamble", tn, 0);
    chk("R2", "payload during preamble", pn, 0);
    send16(16'hBEEF);
    settle();
    chk("R3", "outputs after ignored word", tn + pn, 0);
    send_txt(8'h61, "AB");
    send_txt(8'h62, "X");
    send_txt(8'h63, "");
    send_txt(8'h64, "Q9");
    settle();
    chk("R4", "text count", tn, 5);
    chk("R9", "zero text record adds nothing", tn, 5);
    chk("R4", "char0", {tfld[0], tlst[0], tdat[0]}, {2'd0, 1'b0, 8'h41});
    chk("R4", "char1", {tfld[1], tlst[1], tdat[1]}, {2'd0, 1'b1, 8'h42});
    chk("R4", "char2", {tfld[2], tlst[2], tdat[2]}, {2'd1, 1'b1, 8'h58});
    chk("R4", "char3", {tfld[3], tlst[3], tdat[3]}, {2'd3, 1'b0, 8'h51});
    chk("R4", "char4", {tfld[4], tlst[4], tdat[4]}, {2'd3, 1'b1, 8'h39});
    send(8'h65, 1'b0);
    send32(32'h0000_0105);
    for (int i = 0; i < 260; i++) send(8'(i ^ 8'h5A), 1'b0);
    settle();
    chk("R7", "done before final byte", int'(done), 0);
    send(8'(260 ^ 8'h5A), 1'b0);
    settle();
    chk("R7", "done after final byte", int'(done), 1);
    chk("R5", "payload count", pn, 261);
    begin
      int bad = 0;
      int lasts = 0;
      for (int i = 0; i < pn && i < 512; i++) begin
        if (pdat[i] != 8'(i ^ 8'h5A)) bad++;
        if (plst[i]) lasts++;
      end
      chk("R5", "payload mismatches", bad, 0);
      chk("R5", "last flags", lasts, 1);
      chk("R5", "last on final", int'(plst[260]), 1);
    end
    send(8'h61, 1'b0);
    send(8'h00, 1'b1);
    settle();
    chk("R7", "trailing ignored", tn * 1000 + pn, 5 * 1000 + 261);
    chk("R7", "done held", int'(done), 1);
    chk("R10", "no trunc after done", int'(trunc_err | tag_err), 0);
  endtask

  task automatic t_backpressure();
    do_reset();
    send16(16'h0000);
    send16(16'h0000);
    send(8'h65, 1'b0);
    send32(32'd6);
    bp_mode = 1'b1;
    for (int i = 0; i < 6; i++) send(8'(8'hC0 + i), i == 5);
    bp_mode = 1'b0;
    settle();
    chk("R6", "stalls seen", int'(stalls > 0), 1);
    chk("R6", "payload count", pn, 6);
    for (int i = 0; i < 6; i++) chk("R6", "payload byte", pdat[i], 8'hC0 + i);
    chk("R10", "in_last on final payload", int'(trunc_err), 0);
    chk("R7", "done", int'(done), 1);
  endtask

  task automatic t_zero_pay();
    do_reset();
    send16(16'h0000);
    send16(16'h1234);
    send_txt(8'h64, "");
    send(8'h65, 1'b0);
    send32(32'd0);
    settle();
    chk("R9", "done on zero payload", int'(done), 1);
    chk("R9", "no output", tn + pn, 0);
  endtask

  task automatic t_bad_tag();
    do_reset();
    send16(16'h0000); send16(16'h0000);
    send_txt(8'h61, "Z");
    send(8'h66, 1'b0);
    settle();
    chk("R8", "tag_err on 0x66", int'(tag_err), 1);
    chk("R8", "trunc clear", int'(trunc_err), 0);
    send(8'h61, 1'b0); send(8'h00, 1'b0); send(8'h01, 1'b0); send(8'h6B, 1'b0);
    settle();
    chk("R8", "nothing after error", tn * 100 + pn, 100);
    chk("R8", "still tag_err", int'(tag_err), 1);
    chk("R8", "no done", int'(done), 0);
    do_reset();
    send16(16'h0000); send16(16'h0000);
    send(8'h60, 1'b0);
    settle();
    chk("R8", "tag_err on 0x60", int'(tag_err), 1);
  endtask

  task automatic t_trunc();
    do_reset();
    send16(16'h0000); send16(16'h0000);
    send(8'h62, 1'b0); send16(16'd3);
    send(8'h78, 1'b0); send(8'h79, 1'b1);
    settle();
    chk("R10", "trunc in text", int'(trunc_err), 1);
    chk("R10", "no tag_err", int'(tag_err), 0);
    do_reset();
    send16(16'h0000); send16(16'h0000);
    send(8'h65, 1'b0); send32(32'd5);
    send(8'h11, 1'b0); send(8'h22, 1'b1);
    settle();
    chk("R10", "trunc in payload", int'(trunc_err), 1);
    chk("R10", "no done", int'(done), 0);
    do_reset();
    send16(16'h0000); send16(16'h0000);
    send(8'h7A, 1'b1);
    settle();
    chk("R10", "bad tag with last -> tag_err", int'(tag_err), 1);
    chk("R10", "bad tag with last -> no trunc", int'(trunc_err), 0);
    do_reset();
    send16(16'h0004);
    send(8'h01, 1'b0); send(8'h02, 1'b1);
    settle();
    chk("R10", "trunc in preamble", int'(trunc_err), 1);
  endtask

  task automatic t_midreset();
    do_reset();
    send16(16'h0005);
    send(8'hAA, 1'b0); send(8'hBB, 1'b0);
    do_reset();
    send16(16'h0000); send16(16'h0000);
    send_txt(8'h61, "M");
    send(8'h65, 1'b0); send32(32'd1);
    send(8'h3C, 1'b1);
    settle();
    chk("R11", "text after reset", {tn[7:0], tfld[0], tdat[0]}, {8'd1, 2'd0, 8'h4D});
    chk("R11", "payload after reset", {pn[7:0], pdat[0]}, {8'd1, 8'h3C});
    chk("R11", "done after reset", int'(done), 1);
  endtask

  initial begin
    t_reset();
    t_full();
    t_backpressure();
    t_zero_pay();
    t_bad_tag();
    t_trunc();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule